// File: doc/BRIEF.md
# IOMMU Performance Monitor

This block counts performance events for an I/O memory management unit. A free-running 64-bit cycle counter and a parameterised set of up to 31 event counters live behind a word-wide register interface. Each event counter has its own 64-bit selector. The selector picks one of seven event types and can narrow the count to one device and/or one process.

The translation logic raises one-cycle pulses on `ev_hit`, one bit per event type. Each pulse comes with the requester's device and process identifiers. Software can freeze any counter through the inhibit register and can watch wrap-arounds through the overflow summary. It receives a single interrupt pulse whenever a sticky overflow flag goes from clear to set.

Top module: `iommu_hpm`

## Requirements
- R1: The capability word at offset 0x000 reads bit 0 = 1 when at least one event counter exists and bits [5:1] = the counter count N. N is the `NUM_CTR` parameter clipped to 31.
- R2: The inhibit word at 0x008 uses bit 0 for the cycle counter and bit i for event counter i (1..N). Bits above N read as 1 and ignore writes, so the reset value is ~((2<<N)-1).
- R3: The cycle counter reads as two words, low at 0x010 and high at 0x014. Both are writable. It advances by one every cycle while bit 0 of the inhibit word is clear and holds its value while that bit is set.
- R4: When the low 63 bits of the cycle counter wrap, bit 63 becomes a sticky overflow flag. Bit 0 of the summary word at 0x004 shows that flag live, so writing bit 63 to 0 clears the summary bit at once.
- R5: Selector bits [14:0] hold the event type: 1 untranslated request, 2 translation-service request, 3 TLB miss, 4 device-directory step, 5 process-directory step, 6 first-stage walk step, 7 second-stage walk step. The type goes to `ev_hit` bit (type-1). Type 0 and types above 7 never count.
- R6: Selector bit 15 enables a process filter, which compares against bits [36:17]. Selector bit 16 enables a device filter, which compares against bits [60:37]. A pulse counts only when every enabled filter matches.
- R7: Event counter i sits at 0x100+8*(i-1) (low, high). It does not advance while inhibit bit i is set.
- R8: When an event counter wraps from all ones to zero, its selector bit 63 is set. Bit i of the summary word mirrors that bit.
- R9: `irq` pulses for exactly one cycle when an overflow flag goes from 0 to 1. A wrap while the flag is already set raises no pulse. Writing 0 to the flag re-arms it.
- R10: Selector i sits at 0x200+8*(i-1) (low, high). Only bits [60:0] and 63 hold values, so writing all ones to the high word reads back 0x9FFFFFFF.
- R11: An access with addr[1:0] not zero returns `rsp_err` = 1 and changes no state.
- R12: After reset, all counters, selectors and overflow flags read as zero.
- R13: Every request is answered exactly one cycle later by `rsp_valid`, with read data on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Register access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Byte address of the access |
| wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after req |
| rsp_err | output | 1 | Misaligned access |
| rdata | output | 32 | Read data |
| ev_hit | input | 7 | Event pulses, bit k = event type k+1 |
| ev_did | input | 24 | Device identifier of the pulse |
| ev_pid | input | 20 | Process identifier of the pulse |
| irq | output | 1 | Overflow interrupt pulse |

## Verification
The assertions check the following on every cycle:
- the one-cycle response latency;
- that an error answers only a misaligned address;
- that the cycle counter steps by exactly one when running and holds when inhibited;
- that its overflow flag stays set until software writes it.

The bench scenarios cover what a property cannot show:
- filter matching under random pulse patterns, identifiers and inhibit masks, against a bench model;
- selector write masking and read-only-one inhibit bits;
- live overflow summary;
- the rule that a wrap raises an interrupt only while its flag is clear.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  localparam int HPM_ADDR_W = 10;
  localparam int HPM_CTR_W  = 64;
  localparam int NUM_EVT    = 7;
  localparam int MAX_CTR    = 31;

  typedef enum logic [14:0] {
    EV_NONE      = 15'd0,
    EV_UNTRANS   = 15'd1,
    EV_XLATE_SVC = 15'd2,
    EV_TLB_MISS  = 15'd3,
    EV_DDIR_STEP = 15'd4,
    EV_PDIR_STEP = 15'd5,
    EV_S1_STEP   = 15'd6,
    EV_S2_STEP   = 15'd7
  } hpm_evt_e;

  localparam logic [HPM_ADDR_W-1:0] OFF_CAP = 10'h000;
  localparam logic [HPM_ADDR_W-1:0] OFF_OVF = 10'h004;
  localparam logic [HPM_ADDR_W-1:0] OFF_INH = 10'h008;
  localparam logic [HPM_ADDR_W-1:0] OFF_CYC = 10'h010;
  localparam logic [1:0] REGION_CTL = 2'd0;
  localparam logic [1:0] REGION_CTR = 2'd1;
  localparam logic [1:0] REGION_SEL = 2'd2;

  localparam int SEL_PID_EN  = 15;
  localparam int SEL_DID_EN  = 16;
  localparam int SEL_PID_LSB = 17;
  localparam int SEL_OVF     = 63;
endpackage

// File: rtl/hpm_cycle_ctr.sv
module hpm_cycle_ctr
  import hpm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inh,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [31:0]          wdata,
  output logic [HPM_CTR_W-1:0] cyc_q,
  output logic                 ovf_rise
);
  logic [HPM_CTR_W-1:0] cyc_d;
  logic cnt_en, carry, ld_en;

  always_comb begin
    cnt_en = !inh && !(wr_lo || wr_hi);
    carry  = &cyc_q[HPM_CTR_W-2:0];
    cyc_d  = cyc_q;
    if (cnt_en) begin
      cyc_d[HPM_CTR_W-2:0] = cyc_q[HPM_CTR_W-2:0] + 63'd1;
      cyc_d[HPM_CTR_W-1]   = cyc_q[HPM_CTR_W-1] | carry;
    end
    if (wr_lo) cyc_d[31:0]  = wdata;
    if (wr_hi) cyc_d[63:32] = wdata;
    ovf_rise = cnt_en && carry && !cyc_q[HPM_CTR_W-1];
    ld_en    = cnt_en || wr_lo || wr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cyc_q <= '0;
    else if (ld_en) cyc_q <= cyc_d;
  end
endmodule

// File: rtl/hpm_evt_slice.sv
module hpm_evt_slice
  import hpm_pkg::*;
#(
  parameter int DID_W = 24,
  parameter int PID_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inh,
  input  logic [NUM_EVT-1:0]   ev_hit,
  input  logic [DID_W-1:0]     ev_did,
  input  logic [PID_W-1:0]     ev_pid,
  input  logic                 wr_ctr_lo,
  input  logic                 wr_ctr_hi,
  input  logic                 wr_sel_lo,
  input  logic                 wr_sel_hi,
  input  logic [31:0]          wdata,
  output logic [HPM_CTR_W-1:0] ctr_q,
  output logic [63:0]          sel_q,
  output logic                 ovf_rise
);
  localparam int DID_LSB = SEL_PID_LSB + PID_W;
  localparam logic [63:0] SEL_MASK =
    ((64'd1 << (DID_LSB + DID_W)) - 64'd1) | (64'd1 << SEL_OVF);

  logic [HPM_CTR_W-1:0] ctr_d;
  logic [63:0] sel_d;
  logic [14:0] evt_id;
  logic hit, pid_ok, did_ok, inc, wrap, ctr_en, sel_en;

  always_comb begin
    evt_id = sel_q[14:0];
    hit = 1'b0;
    for (int e = 0; e < NUM_EVT; e++)
      if (evt_id == 15'(e + 1) && ev_hit[e]) hit = 1'b1;
    pid_ok = !sel_q[SEL_PID_EN] || (sel_q[SEL_PID_LSB +: PID_W] == ev_pid);
    did_ok = !sel_q[SEL_DID_EN] || (sel_q[DID_LSB +: DID_W] == ev_did);
    inc    = hit && pid_ok && did_ok && !inh && !(wr_ctr_lo || wr_ctr_hi);
    wrap   = inc && (&ctr_q);

    ctr_d = ctr_q;
    if (inc)       ctr_d = ctr_q + 64'd1;
    if (wr_ctr_lo) ctr_d[31:0]  = wdata;
    if (wr_ctr_hi) ctr_d[63:32] = wdata;

    sel_d = sel_q;
    if (wr_sel_lo) sel_d[31:0]  = wdata;
    if (wr_sel_hi) sel_d[63:32] = wdata;
    sel_d = sel_d & SEL_MASK;
    if (wrap) sel_d[SEL_OVF] = 1'b1;

    ovf_rise = wrap && !sel_q[SEL_OVF];
    ctr_en   = inc || wr_ctr_lo || wr_ctr_hi;
    sel_en   = wrap || wr_sel_lo || wr_sel_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
      sel_q <= '0;
    end else begin
      if (ctr_en) ctr_q <= ctr_d;
      if (sel_en) sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/iommu_hpm.sv
module iommu_hpm
  import hpm_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int DID_W   = 24,
  parameter int PID_W   = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [HPM_ADDR_W-1:0] addr,
  input  logic [31:0]           wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [31:0]           rdata,
  input  logic [NUM_EVT-1:0]    ev_hit,
  input  logic [DID_W-1:0]      ev_did,
  input  logic [PID_W-1:0]      ev_pid,
  output logic                  irq
);
  localparam int N    = (NUM_CTR > MAX_CTR) ? MAX_CTR : ((NUM_CTR < 0) ? 0 : NUM_CTR);
  localparam int MAXS = (N > 0) ? N : 1;
  localparam logic [31:0] INH_RO = ~32'((33'd2 << N) - 33'd1);
  localparam logic [31:0] CAP_VAL = {26'd0, 5'(N), (N > 0)};

  logic rst_meta, rst_s_n;
  logic [N:0] inh_q, inh_d;
  logic inh_wr;
  logic [HPM_CTR_W-1:0] cyc_q;
  logic cyc_wr_lo, cyc_wr_hi, cyc_rise;
  logic [HPM_CTR_W-1:0] ctr_q [MAXS];
  logic [63:0] sel_q [MAXS];
  logic [MAXS-1:0] wr_ctr_lo, wr_ctr_hi, wr_sel_lo, wr_sel_hi, ev_rise;
  logic [1:0] region;
  logic [4:0] slot;
  logic hi_half, aligned, wr_ok;
  logic [31:0] rd_val, ovf_sum, rdata_d;
  logic rsp_valid_d, rsp_err_d, irq_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s_n  <= rst_meta;
    end
  end

  always_comb begin
    region  = addr[9:8];
    slot    = addr[7:3];
    hi_half = addr[2];
    aligned = (addr[1:0] == 2'b00);
    wr_ok   = req && we && aligned;
    inh_wr  = wr_ok && (addr == OFF_INH);
    inh_d   = wdata[N:0];
    cyc_wr_lo = wr_ok && (addr == OFF_CYC);
    cyc_wr_hi = wr_ok && (addr == OFF_CYC + 10'd4);
    for (int i = 0; i < MAXS; i++) begin
      wr_ctr_lo[i] = wr_ok && region == REGION_CTR && slot == 5'(i) && !hi_half;
      wr_ctr_hi[i] = wr_ok && region == REGION_CTR && slot == 5'(i) &&  hi_half;
      wr_sel_lo[i] = wr_ok && region == REGION_SEL && slot == 5'(i) && !hi_half;
      wr_sel_hi[i] = wr_ok && region == REGION_SEL && slot == 5'(i) &&  hi_half;
    end
  end

  hpm_cycle_ctr u_cyc (
    .clk(clk), .rst_n(rst_s_n), .inh(inh_q[0]), .wr_lo(cyc_wr_lo),
    .wr_hi(cyc_wr_hi), .wdata(wdata), .cyc_q(cyc_q), .ovf_rise(cyc_rise)
  );

  generate
    if (N == 0) begin : g_none
      assign ctr_q[0] = '0;
      assign sel_q[0] = '0;
      assign ev_rise  = '0;
    end else begin : g_slices
      for (genvar gi = 0; gi < N; gi++) begin : g_slice
        hpm_evt_slice #(.DID_W(DID_W), .PID_W(PID_W)) u_slice (
          .clk(clk), .rst_n(rst_s_n), .inh(inh_q[gi+1]), .ev_hit(ev_hit),
          .ev_did(ev_did), .ev_pid(ev_pid),
          .wr_ctr_lo(wr_ctr_lo[gi]), .wr_ctr_hi(wr_ctr_hi[gi]),
          .wr_sel_lo(wr_sel_lo[gi]), .wr_sel_hi(wr_sel_hi[gi]),
          .wdata(wdata), .ctr_q(ctr_q[gi]), .sel_q(sel_q[gi]),
          .ovf_rise(ev_rise[gi])
        );
      end
    end
  endgenerate

  always_comb begin
    ovf_sum    = '0;
    ovf_sum[0] = cyc_q[HPM_CTR_W-1];
    for (int i = 0; i < N; i++) ovf_sum[i+1] = sel_q[i][SEL_OVF];

    rd_val = '0;
    case (region)
      REGION_CTL: begin
        if (addr == OFF_CAP)             rd_val = CAP_VAL;
        else if (addr == OFF_OVF)        rd_val = ovf_sum;
        else if (addr == OFF_INH)        rd_val = INH_RO | 32'(inh_q);
        else if (addr == OFF_CYC)        rd_val = cyc_q[31:0];
        else if (addr == OFF_CYC + 10'd4) rd_val = cyc_q[63:32];
      end
      REGION_CTR:
        for (int i = 0; i < N; i++)
          if (slot == 5'(i)) rd_val = hi_half ? ctr_q[i][63:32] : ctr_q[i][31:0];
      REGION_SEL:
        for (int i = 0; i < N; i++)
          if (slot == 5'(i)) rd_val = hi_half ? sel_q[i][63:32] : sel_q[i][31:0];
      default: rd_val = '0;
    endcase

    rsp_valid_d = req;
    rsp_err_d   = req && !aligned;
    rdata_d     = (req && !we && aligned) ? rd_val : '0;
    irq_d       = cyc_rise || (|ev_rise);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      inh_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rdata     <= '0;
      irq       <= 1'b0;
    end else begin
      if (inh_wr) inh_q <= inh_d;
      rsp_valid <= rsp_valid_d;
      rsp_err   <= rsp_err_d;
      rdata     <= rdata_d;
      irq       <= irq_d;
    end
  end
endmodule

// File: rtl/hpm_chk.sv
module hpm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic [1:0]  addr_lo,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] cyc_q,
  input logic        cyc_inh,
  input logic        cyc_wr
);
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req)); // R13
  AST_ERR_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && $past(addr_lo) != 2'b00)); // R11
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_inh && !cyc_wr && !(&cyc_q[62:0])) |=> (cyc_q[62:0] == $past(cyc_q[62:0]) + 63'd1)); // R3
  AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_inh && !cyc_wr) |=> $stable(cyc_q)); // R3
  AST_CYC_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q[63] && !cyc_wr) |=> cyc_q[63]); // R4
endmodule

bind iommu_hpm hpm_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .req(req), .addr_lo(addr[1:0]),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .cyc_q(cyc_q),
  .cyc_inh(inh_q[0]), .cyc_wr(cyc_wr_lo | cyc_wr_hi)
);

// File: tb/sim_iommu_hpm.sv
module sim_iommu_hpm;
  localparam int NB = 4;
  logic clk = 1'b0;
  logic rst_n, req, we, rsp_valid, rsp_err, irq;
  logic [9:0] addr;
  logic [31:0] wdata, rdata;
  logic [6:0] ev_hit;
  logic [23:0] ev_did;
  logic [19:0] ev_pid;
  int checks = 0, fails = 0, irq_cnt = 0;
  logic last_err, last_valid;

  always #5 clk = ~clk;

  iommu_hpm u0 (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rdata(rdata),
    .ev_hit(ev_hit), .ev_did(ev_did), .ev_pid(ev_pid), .irq(irq));

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bus_wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; last_err = rsp_err; last_valid = rsp_valid;
  endtask

  task automatic bus_rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata; last_err = rsp_err; last_valid = rsp_valid;
  endtask

  task automatic pulse(logic [6:0] h);
    @(negedge clk); ev_hit = h; ev_did = 24'h0; ev_pid = 20'h0;
    @(negedge clk); ev_hit = '0;
  endtask

  function automatic logic [31:0] inh_ro(int n);
    return ~32'((33'd2 << n) - 33'd1);
  endfunction

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int exp_c [3];
    logic inh3;
    void'($urandom(32'd20240607));
    rst_n = 0; req = 0; we = 0; addr = '0; wdata = '0;
    ev_hit = '0; ev_did = '0; ev_pid = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R12 reset state
    bus_rd(10'h000, v); chk("R1 capability", v, 32'((NB << 1) | 1));
    chk("R13 response strobe", {31'd0, last_valid}, 32'd1);
    bus_rd(10'h008, v); chk("R2 inhibit reset", v, inh_ro(NB));
    bus_rd(10'h004, v); chk("R12 summary reset", v, 32'd0);
    for (int i = 0; i < NB; i++) begin
      bus_rd(10'(32'h100 + 8*i), v); chk("R12 counter low", v, 0);
      bus_rd(10'(32'h104 + 8*i), v); chk("R12 counter high", v, 0);
      bus_rd(10'(32'h200 + 8*i), v); chk("R12 selector low", v, 0);
      bus_rd(10'(32'h204 + 8*i), v); chk("R12 selector high", v, 0);
    end

    // R2 read-only ones above N
    bus_wr(10'h008, 32'h0); bus_rd(10'h008, v); chk("R2 upper bits stay 1", v, inh_ro(NB));
    bus_wr(10'h008, 32'hFFFF_FFFF); bus_rd(10'h008, v); chk("R2 all set", v, 32'hFFFF_FFFF);

    // R3 cycle counter write and freeze
    bus_wr(10'h010, 32'h1111_1111); bus_wr(10'h014, 32'h2);
    bus_rd(10'h010, v); chk("R3 cycle low write", v, 32'h1111_1111);
    bus_rd(10'h014, v); chk("R3 cycle high write", v, 32'h2);
    repeat (10) @(negedge clk);
    bus_rd(10'h010, v); chk("R3 cycle frozen", v, 32'h1111_1111);
    bus_wr(10'h008, 32'h1E);
    bus_rd(10'h010, v); bus_rd(10'h010, v2);
    chk("R3 cycle advance", v2 - v, 32'd2);

    // R4 cycle overflow, live summary, interrupt
    bus_wr(10'h008, 32'hFFFF_FFFF);
    bus_wr(10'h014, 32'h7FFF_FFFF); bus_wr(10'h010, 32'hFFFF_FFF0);
    v2 = 32'(irq_cnt);
    bus_wr(10'h008, 32'h1E);
    repeat (30) @(negedge clk);
    bus_rd(10'h004, v); chk("R4 summary cycle bit", v, 32'h1);
    bus_rd(10'h014, v); chk("R4 cycle flag", v, 32'h8000_0000);
    chk("R9 cycle overflow pulse", 32'(irq_cnt) - v2, 32'd1);
    bus_wr(10'h008, 32'hFFFF_FFFF); bus_wr(10'h014, 32'h0);
    bus_rd(10'h004, v); chk("R4 summary follows flag", v, 32'h0);

    // R10 selector masking
    bus_wr(10'h200, 32'hFFFF_FFFF); bus_wr(10'h204, 32'hFFFF_FFFF);
    bus_rd(10'h200, v); chk("R10 selector low", v, 32'hFFFF_FFFF);
    bus_rd(10'h204, v); chk("R10 selector high mask", v, 32'h9FFF_FFFF);
    bus_wr(10'h200, 32'h0); bus_wr(10'h204, 32'h0);

    // R11 misaligned access
    bus_wr(10'h202, 32'h5); chk("R11 write error", {31'd0, last_err}, 32'd1);
    bus_rd(10'h200, v); chk("R11 no effect", v, 32'h0);
    chk("R11 aligned no error", {31'd0, last_err}, 32'd0);
    bus_rd(10'h101, v); chk("R11 read error", {31'd0, last_err}, 32'd1);

    // R5 R6 R7 random events against a model
    bus_wr(10'h200, 32'd3);
    bus_wr(10'h208, 32'd4 | (32'd1 << 16)); bus_wr(10'h20C, 32'h12 << 5);
    bus_wr(10'h210, 32'd6 | (32'd1 << 15) | (32'd1 << 16) | (32'd5 << 17));
    bus_wr(10'h214, 32'h34 << 5);
    bus_wr(10'h218, 32'd0);
    bus_wr(10'h008, 32'h0);
    exp_c = '{0, 0, 0};
    inh3 = 0;
    for (int ph = 0; ph < 2; ph++) begin
      if (ph == 1) begin bus_wr(10'h008, 32'h08); inh3 = 1; end
      for (int k = 0; k < 300; k++) begin
        logic [6:0] h;
        logic [23:0] d;
        logic [19:0] p;
        h = 7'($urandom);
        case ($urandom % 3) 0: d = 24'h12; 1: d = 24'h34; default: d = 24'h99; endcase
        p = ($urandom % 2 == 0) ? 20'd5 : 20'd6;
        @(negedge clk); ev_hit = h; ev_did = d; ev_pid = p;
        if (h[2]) exp_c[0]++;
        if (h[3] && d == 24'h12) exp_c[1]++;
        if (h[5] && d == 24'h34 && p == 20'd5 && !inh3) exp_c[2]++;
      end
      @(negedge clk); ev_hit = '0;
    end
    bus_rd(10'h100, v); chk("R5 TLB miss count", v, 32'(exp_c[0]));
    bus_rd(10'h104, v); chk("R5 count high", v, 0);
    bus_rd(10'h108, v); chk("R6 device filter count", v, 32'(exp_c[1]));
    bus_rd(10'h110, v); chk("R7 inhibited filtered count", v, 32'(exp_c[2]));
    bus_rd(10'h118, v); chk("R5 type zero never counts", v, 0);

    // R8 R9 event wrap and interrupt rules
    bus_wr(10'h008, 32'h1);
    bus_wr(10'h200, 32'd1); bus_wr(10'h204, 32'd0);
    bus_wr(10'h104, 32'hFFFF_FFFF); bus_wr(10'h100, 32'hFFFF_FFFE);
    v2 = 32'(irq_cnt);
    pulse(7'h01); pulse(7'h01);
    repeat (2) @(negedge clk);
    bus_rd(10'h100, v); chk("R8 wrapped low", v, 0);
    bus_rd(10'h104, v); chk("R8 wrapped high", v, 0);
    bus_rd(10'h204, v); chk("R8 selector flag", v, 32'h8000_0000);
    bus_rd(10'h004, v); chk("R8 summary bit", v, 32'h2);
    chk("R9 single pulse", 32'(irq_cnt) - v2, 32'd1);
    bus_wr(10'h100, 32'hFFFF_FFFF); bus_wr(10'h104, 32'hFFFF_FFFF);
    pulse(7'h01); repeat (2) @(negedge clk);
    chk("R9 no pulse while flag set", 32'(irq_cnt) - v2, 32'd1);
    bus_wr(10'h204, 32'h0);
    bus_rd(10'h004, v); chk("R9 flag cleared", v, 32'h0);
    bus_wr(10'h100, 32'hFFFF_FFFF); bus_wr(10'h104, 32'hFFFF_FFFF);
    pulse(7'h01); repeat (2) @(negedge clk);
    chk("R9 re-armed pulse", 32'(irq_cnt) - v2, 32'd2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule